// File: doc/BRIEF.md
# Dual Video Stream Frame Aligner

Two parallel video streams share one pixel clock, but their frames begin at unrelated moments. This block delays stream A through a one-frame store. When stream B reaches the top of its frame, the two streams leave the block as a pair whose frame starts coincide.

Every stream A pixel is written into an on-chip buffer. The first pixel of each A frame lands at address zero. When B marks the start of a frame, the block plays the buffer back from address zero, one word for every valid B pixel. The stored A word and the live B word come out together.

The output carries an aligned valid flag and an aligned start-of-frame flag. Both streams take the same single cycle of latency. A sticky `locked` flag shows that alignment has been reached.

Top module: `dual_stream_aligner`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `out_sof` and `locked` are 0.
- R2: A stream B start-of-frame seen before any stream A start-of-frame has no effect: `out_valid` and `locked` stay 0. Stream A pixels that arrive before the first A start-of-frame are not stored.
- R3: `locked` rises one cycle after the first valid stream B start-of-frame that occurs strictly after the cycle of the first valid stream A start-of-frame. A B start-of-frame in that same cycle does not lock.
- R4: Once locked, every valid B pixel appears one cycle later on `out_b_data`, with `out_valid` high. A cycle with `b_valid` low gives `out_valid` low one cycle later.
- R5: `out_a_data` comes from the buffer, never from the live A input. The k-th valid B pixel after a B start-of-frame (counting from 0) is paired with buffer address k.
- R6: `out_sof` is high only together with the output pair of a valid B start-of-frame pixel, and only once locked.
- R7: The write address and the read address each wrap from FRAME_PIXELS-1 back to 0.
- R8: A cycle with `a_valid` low does not advance the write address. A cycle with `b_valid` low does not advance the read address.
- R9: A read and a write to the same address in the same cycle return the A word being written in that cycle.
- R10: `locked` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_data | input | DATA_W | Stream A pixel word |
| a_valid | input | 1 | Stream A pixel qualifier |
| a_sof | input | 1 | Stream A first pixel of frame |
| b_data | input | DATA_W | Stream B pixel word |
| b_valid | input | 1 | Stream B pixel qualifier |
| b_sof | input | 1 | Stream B first pixel of frame |
| out_a_data | output | DATA_W | Stream A word read from the buffer |
| out_b_data | output | DATA_W | Stream B word, delayed one cycle |
| out_valid | output | 1 | Output pair qualifier |
| out_sof | output | 1 | Output pair is the first of a frame |
| locked | output | 1 | Alignment reached, sticky until reset |

## Verification
The buffer write for stream A and the playback read for stream B can hit the same address in the same cycle. The obvious case is both start-of-frame markers arriving together. The other case is a write that has wrapped past the frame length catching up with the read. The bench provokes both with a reduced FRAME_PIXELS of 4. It expects the new A word, not the stale stored one, on `out_a_data` one cycle later. The bench also drives pixels that are invalid on one side only, so that the two pointers drift apart and a later read returns older stored data.

// File: rtl/dual_stream_aligner.sv
module dual_stream_aligner #(
  parameter int DATA_W       = 10,
  parameter int FRAME_PIXELS = 1920
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_data,
  input  logic              a_valid,
  input  logic              a_sof,
  input  logic [DATA_W-1:0] b_data,
  input  logic              b_valid,
  input  logic              b_sof,
  output logic [DATA_W-1:0] out_a_data,
  output logic [DATA_W-1:0] out_b_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              locked
);
  localparam int AW = (FRAME_PIXELS > 1) ? $clog2(FRAME_PIXELS) : 1;
  localparam logic [AW-1:0] LAST = AW'(FRAME_PIXELS - 1);

  logic [DATA_W-1:0] store [FRAME_PIXELS];
  logic              filling;
  logic [AW-1:0]     wr_ptr, rd_ptr;

  wire          wr_en    = a_valid & (a_sof | filling);
  wire [AW-1:0] wr_addr  = a_sof ? '0 : wr_ptr;
  wire          b_start  = b_valid & b_sof;
  wire          lock_now = b_start & filling;
  wire          rd_en    = b_valid & (locked | lock_now);
  wire [AW-1:0] rd_addr  = b_sof ? '0 : rd_ptr;
  wire          collide  = wr_en & (wr_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= a_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling    <= 1'b0;
      locked     <= 1'b0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      out_valid  <= 1'b0;
      out_sof    <= 1'b0;
      out_a_data <= '0;
      out_b_data <= '0;
    end else begin
      if (a_valid & a_sof) filling <= 1'b1;
      if (lock_now)        locked  <= 1'b1;
      if (wr_en) wr_ptr <= (wr_addr == LAST) ? '0 : wr_addr + AW'(1);
      if (rd_en) begin
        rd_ptr     <= (rd_addr == LAST) ? '0 : rd_addr + AW'(1);
        out_a_data <= collide ? a_data : store[rd_addr];
        out_b_data <= b_data;
      end
      out_valid <= rd_en;
      out_sof   <= rd_en & b_sof;
    end
  end
endmodule

module dual_stream_aligner_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_valid,
  input logic              a_sof,
  input logic              b_valid,
  input logic [DATA_W-1:0] b_data,
  input logic [DATA_W-1:0] out_b_data,
  input logic              out_valid,
  input logic              out_sof,
  input logic              locked
);
  logic seen_a;
  always_ff @(posedge clk) begin
    if (!rst_n)                seen_a <= 1'b0;
    else if (a_valid && a_sof) seen_a <= 1'b1;
  end

  // R2
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_a |-> (!out_valid && !locked));

  // R4
  b_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && b_valid) |=> (out_valid && out_b_data == $past(b_data)));

  // R6
  sof_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_valid && locked));

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R4
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> locked);
endmodule

bind dual_stream_aligner dual_stream_aligner_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_sof(a_sof),
  .b_valid(b_valid), .b_data(b_data), .out_b_data(out_b_data),
  .out_valid(out_valid), .out_sof(out_sof), .locked(locked)
);

// File: tb/dual_stream_aligner_test.sv
module dual_stream_aligner_test;
  localparam int DW = 8;
  localparam int FP = 4;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic a_valid = 1'b0, a_sof = 1'b0, b_valid = 1'b0, b_sof = 1'b0;
  logic [DW-1:0] out_a_data, out_b_data;
  logic out_valid, out_sof, locked;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dual_stream_aligner #(.DATA_W(DW), .FRAME_PIXELS(FP)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_data(a_data), .a_valid(a_valid), .a_sof(a_sof),
    .b_data(b_data), .b_valid(b_valid), .b_sof(b_sof),
    .out_a_data(out_a_data), .out_b_data(out_b_data),
    .out_valid(out_valid), .out_sof(out_sof), .locked(locked)
  );

  // row: av as ad bv bs bd | exp valid, sof, locked, a, b
  function automatic logic [38:0] mk(input logic av, as, input logic [7:0] ad,
                                     input logic bv, bs, input logic [7:0] bd,
                                     input logic ev, es, el,
                                     input logic [7:0] ea, eb);
    return {av, as, ad, bv, bs, bd, ev, es, el, ea, eb};
  endfunction

  localparam logic [38:0] VEC [NV] = '{
    mk(0,0,8'h00, 1,1,8'hB0, 0,0,0, 8'h00,8'h00), // R2 B sof before A
    mk(1,1,8'h10, 1,1,8'hB1, 0,0,0, 8'h00,8'h00), // R3 same-cycle SOFs do not lock
    mk(1,0,8'h11, 1,0,8'hB2, 0,0,0, 8'h00,8'h00),
    mk(1,0,8'h12, 0,0,8'h00, 0,0,0, 8'h00,8'h00),
    mk(1,0,8'h13, 0,0,8'h00, 0,0,0, 8'h00,8'h00),
    mk(1,1,8'h20, 1,1,8'hC0, 1,1,1, 8'h20,8'hC0), // R3 R6 R9 lock, collide at 0
    mk(1,0,8'h21, 1,0,8'hC1, 1,0,1, 8'h21,8'hC1), // R9
    mk(0,0,8'h00, 1,0,8'hC2, 1,0,1, 8'h12,8'hC2), // R5 R8 older stored word
    mk(1,0,8'h22, 0,0,8'h00, 0,0,1, 8'h00,8'h00), // R4 R8 no B pixel
    mk(1,0,8'h23, 1,0,8'hC3, 1,0,1, 8'h23,8'hC3),
    mk(1,0,8'h24, 1,0,8'hC4, 1,0,1, 8'h24,8'hC4), // R7 both wrap to 0
    mk(0,0,8'h00, 1,1,8'hD0, 1,1,1, 8'h24,8'hD0), // R5 R6 new B frame
    mk(0,0,8'h00, 1,0,8'hD1, 1,0,1, 8'h21,8'hD1), // R5
    mk(0,0,8'h00, 0,0,8'h00, 0,0,1, 8'h00,8'h00)  // R10 holds
  };

  task automatic check(input logic ok, input string what, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic av, as, input logic [7:0] ad,
                       input logic bv, bs, input logic [7:0] bd);
    a_valid = av; a_sof = as; a_data = ad;
    b_valid = bv; b_sof = bs; b_data = bd;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !out_sof && !locked, "R1 reset outputs", {out_valid, out_sof, locked}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [38:0] r;
      r = VEC[i];
      drive(r[38], r[37], r[36:29], r[28], r[27], r[26:19]);
      check(out_valid == r[18], $sformatf("R4 valid row %0d", i), out_valid, r[18]);
      check(out_sof == r[17], $sformatf("R6 sof row %0d", i), out_sof, r[17]);
      check(locked == r[16], $sformatf("R3 locked row %0d", i), locked, r[16]);
      if (r[18]) begin
        check(out_a_data == r[15:8], $sformatf("R5 a data row %0d", i), out_a_data, r[15:8]);
        check(out_b_data == r[7:0], $sformatf("R4 b data row %0d", i), out_b_data, r[7:0]);
      end
    end

    // R1 R10: reset clears a held lock
    rst_n = 1'b0;
    drive(0,0,8'h00, 0,0,8'h00);
    check(!locked && !out_valid, "R10 lock cleared by reset", {locked, out_valid}, 0);
    rst_n = 1'b1;

    // R2: A pixels without SOF, then B SOF: nothing stored, no lock
    drive(1,0,8'h55, 0,0,8'h00);
    drive(1,0,8'h56, 1,1,8'hE0);
    check(!locked && !out_valid, "R2 no lock without A sof", {locked, out_valid}, 0);

    // R3 R5: A sof, then B sof next cycle locks and reads that A word
    drive(1,1,8'h30, 0,0,8'h00);
    drive(0,0,8'h00, 1,1,8'hE1);
    check(locked && out_sof && out_valid, "R3 lock one cycle after B sof",
          {locked, out_sof, out_valid}, 3'b111);
    check(out_a_data == 8'h30, "R5 stored A word at address 0", out_a_data, 8'h30);
    check(out_b_data == 8'hE1, "R4 live B word", out_b_data, 8'hE1);

    // R8: b_sof without b_valid is ignored
    drive(0,0,8'h00, 0,1,8'hEE);
    check(!out_valid && !out_sof, "R8 invalid B sof ignored", {out_valid, out_sof}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule